// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Status Unit

This unit derives the interrupt conditions of a synchronous serial port that buffers received frames in one FIFO and frames waiting to be sent in another. It does not hold any frame data. It watches the occupancy counts of both FIFOs, a strobe that marks a complete received frame, a strobe that marks a read from the receive FIFO, and a tick that marks each serial bit period. From these inputs it forms four conditions. Two of them are sticky events: a frame that lands on a full receive FIFO, and receive data that has sat unread for too long. The other two are levels: the receive FIFO is half full or more, and the transmit FIFO is half empty or more.

Software sees the conditions through a small register window. One register holds the enable mask. One shows the unmasked conditions. One shows the conditions after the mask is applied. A single interrupt line is raised whenever any enabled condition is active. The sticky events are cleared through a dedicated write-one-to-clear pulse input.

Top module: `spi_irq_status`

## Requirements
- R1: Every status and mask word uses this layout: bit 0 is receive overrun, bit 1 is receive timeout, bit 2 is receive FIFO half full, and bit 3 is transmit FIFO half empty. Bits 31:4 always read 0.
- R2: During synchronous active-low reset, and on the first cycle after it, the mask reads 0 and both sticky flags are 0. With the transmit FIFO empty and the receive FIFO empty, the raw status reads 0x8 and `irq` is 0.
- R3: The raw status (`reg_sel`=1) shows every active condition, whatever the mask holds.
- R4: The masked status (`reg_sel`=2) reads as raw status AND mask. `reg_sel`=0 reads the mask and `reg_sel`=3 reads 0. The read data is combinational.
- R5: `irq` is 1 exactly when at least one bit of the masked status is 1.
- R6: If `rx_frame_done` is high while `rx_level` equals DEPTH and `rx_pop` is low, the overrun bit reads 1 from the next cycle on. It then stays set until it is cleared.
- R7: A timeout count advances on each `bit_tick` and saturates at 32. It restarts on `rx_pop`, on `rx_frame_done`, or while `rx_level` is 0. The timeout bit reads 1 from the cycle after the tick that brings the count to 32.
- R8: A pulse on `clr_w1c[0]` clears the overrun flag and a pulse on `clr_w1c[1]` clears the timeout flag, each at the next edge. If a set and a clear of the same flag fall in one cycle, the set wins.
- R9: The receive half-full bit is 1 exactly while `rx_level` >= DEPTH/2.
- R10: The transmit half-empty bit is 1 exactly while `tx_level` <= DEPTH/2.
- R11: A write with `reg_we`=1 and `reg_sel`=0 stores only `reg_wdata[3:0]` in the mask. Writes to bits 31:4 are ignored, and writes to any other select have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO occupancy |
| tx_level | input | $clog2(DEPTH+1) | Transmit FIFO occupancy |
| rx_frame_done | input | 1 | A complete frame was received this cycle |
| rx_pop | input | 1 | The receive FIFO was read this cycle |
| bit_tick | input | 1 | One serial bit period has elapsed |
| clr_w1c | input | 2 | Clear pulses: bit 0 clears overrun, bit 1 clears timeout |
| reg_sel | input | 2 | Register select: 0 mask, 1 raw, 2 masked, 3 none |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Combined interrupt |

## Verification
Two situations can put competing actions in the same cycle. The first is a sticky flag being set by its event while software pulses the matching clear. The second is a timeout count reaching 32 in the cycle where a pop or a new frame restarts it. The bench provokes both on purpose. It drives an overrun frame together with the overrun clear, and a 32nd tick together with the timeout clear or a pop. A behavioural model decides the outcome every cycle: set wins over clear, and a restart suppresses the set. The bench then compares the raw and masked reads and `irq` against that model.

// File: rtl/spi_irq_pkg.sv
// Shared definitions for the serial port interrupt status unit.
// Assumes a 2-bit register select and a 4-bit condition vector.
package spi_irq_pkg;
    localparam int IRQ_W   = 4;
    localparam int IDX_OVR = 0;
    localparam int IDX_TMO = 1;
    localparam int IDX_RXH = 2;
    localparam int IDX_TXH = 3;
    localparam int DATA_W  = 32;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_RAW  = 2'd1,
        SEL_MIS  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/spi_irq_timeout.sv
// Receive idle timeout: counts bit ticks while unread data waits in the
// receive FIFO and raises a sticky flag when the count first reaches
// TMO_BITS. Assumes at most one bit tick per clock.
module spi_irq_timeout #(
    parameter int DEPTH    = 8,
    parameter int TMO_BITS = 32,
    localparam int LVL_W   = $clog2(DEPTH + 1),
    localparam int TMO_W   = $clog2(TMO_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_pop,
    input  logic             rx_frame_done,
    input  logic             bit_tick,
    input  logic             clr,
    output logic             flag
);
    logic [TMO_W-1:0] cnt_q;
    logic             restart;
    logic             hit;

    // Decide whether the count restarts or completes this cycle.
    always_comb begin
        restart = rx_pop || rx_frame_done || (rx_level == '0);
        hit     = !restart && bit_tick && (cnt_q == TMO_W'(TMO_BITS - 1));
    end

    // Idle counter, saturating at TMO_BITS.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (bit_tick && (cnt_q != TMO_W'(TMO_BITS)))
            cnt_q <= cnt_q + 1'b1;
    end

    // Sticky timeout flag; a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/spi_irq_events.sv
// Overrun detection and the two FIFO threshold levels.
// Assumes that rx_level reaches DEPTH only when the receive FIFO is full.
module spi_irq_events #(
    parameter int DEPTH  = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int HALF  = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             rx_frame_done,
    input  logic             rx_pop,
    input  logic             clr,
    output logic             ovr_flag,
    output logic             rx_half,
    output logic             tx_half
);
    logic ovr_hit;

    // A frame lands on a full FIFO that is not being drained this cycle.
    always_comb ovr_hit = rx_frame_done && !rx_pop && (rx_level == LVL_W'(DEPTH));

    // Sticky overrun flag; a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_flag <= 1'b0;
        else if (ovr_hit)
            ovr_flag <= 1'b1;
        else if (clr)
            ovr_flag <= 1'b0;
    end

    // Level thresholds that follow the FIFO counts directly.
    always_comb begin
        rx_half = (rx_level >= LVL_W'(HALF));
        tx_half = (tx_level <= LVL_W'(HALF));
    end
endmodule

// File: rtl/spi_irq_regs.sv
// Mask register, read-back multiplexer and the combined interrupt line.
// Assumes single-cycle writes and a combinational read path.
module spi_irq_regs
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [IRQ_W-1:0]  raw,
    output logic [IRQ_W-1:0]  mask,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [IRQ_W-1:0] masked;
    reg_sel_e         sel;

    // Mask register keeps only the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (reg_we && (reg_sel_e'(reg_sel) == SEL_MASK))
            mask <= reg_wdata[IRQ_W-1:0];
    end

    // Masked view, read multiplexer and combined interrupt.
    always_comb begin
        sel       = reg_sel_e'(reg_sel);
        masked    = raw & mask;
        reg_rdata = '0;
        unique case (sel)
            SEL_MASK: reg_rdata[IRQ_W-1:0] = mask;
            SEL_RAW:  reg_rdata[IRQ_W-1:0] = raw;
            SEL_MIS:  reg_rdata[IRQ_W-1:0] = masked;
            SEL_NONE: reg_rdata = '0;
        endcase
        irq = |masked;
    end
endmodule

// File: rtl/spi_irq_status.sv
// Top of the serial port interrupt status unit. It collects the four
// conditions into the raw status vector and hands that vector to the
// register block. Assumes the FIFO levels are synchronous to clk.
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int TMO_BITS = 32,
    localparam int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              rx_frame_done,
    input  logic              rx_pop,
    input  logic              bit_tick,
    input  logic [1:0]        clr_w1c,
    input  logic [1:0]        reg_sel,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic             ovr_flag, tmo_flag, rx_half, tx_half;
    logic [IRQ_W-1:0] raw_stat;
    logic [IRQ_W-1:0] mask_q;

    spi_irq_events #(.DEPTH(DEPTH)) u_events (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
        .rx_frame_done(rx_frame_done), .rx_pop(rx_pop), .clr(clr_w1c[0]),
        .ovr_flag(ovr_flag), .rx_half(rx_half), .tx_half(tx_half)
    );

    spi_irq_timeout #(.DEPTH(DEPTH), .TMO_BITS(TMO_BITS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_pop(rx_pop),
        .rx_frame_done(rx_frame_done), .bit_tick(bit_tick),
        .clr(clr_w1c[1]), .flag(tmo_flag)
    );

    // Assemble the raw status in its fixed bit order.
    always_comb begin
        raw_stat          = '0;
        raw_stat[IDX_OVR] = ovr_flag;
        raw_stat[IDX_TMO] = tmo_flag;
        raw_stat[IDX_RXH] = rx_half;
        raw_stat[IDX_TXH] = tx_half;
    end

    spi_irq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .raw(raw_stat), .mask(mask_q),
        .reg_rdata(reg_rdata), .irq(irq)
    );
endmodule

// File: rtl/spi_irq_checker.sv
// Property checker for the interrupt status unit, bound to the top.
module spi_irq_checker #(
    parameter int DEPTH  = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level,
    input logic             rx_frame_done,
    input logic             rx_pop,
    input logic [1:0]       clr_w1c,
    input logic [1:0]       reg_sel,
    input logic [31:0]      reg_rdata,
    input logic             irq,
    input logic [3:0]       raw,
    input logic [3:0]       mask
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:4] == '0);                                          // R1
    AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(raw & mask));                                           // R5
    AST_MIS_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel == 2'd2 |-> reg_rdata[3:0] == (raw & mask));            // R4
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_done && !rx_pop && rx_level == LVL_W'(DEPTH)) |=> raw[0]); // R6
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[0] && !clr_w1c[0]) |=> raw[0]);                            // R8
    AST_TMO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw[1]) |-> $past(clr_w1c[1]));                           // R8
    AST_RX_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel == 2'd1 |-> reg_rdata[2] == (rx_level >= LVL_W'(DEPTH / 2))); // R9
    AST_TX_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel == 2'd1 |-> reg_rdata[3] == (tx_level <= LVL_W'(DEPTH / 2))); // R10
endmodule

bind spi_irq_status spi_irq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .rx_frame_done(rx_frame_done), .rx_pop(rx_pop), .clr_w1c(clr_w1c),
    .reg_sel(reg_sel), .reg_rdata(reg_rdata), .irq(irq),
    .raw(raw_stat), .mask(mask_q)
);

// File: tb/sim_spi_irq_status.sv
// Bench for the interrupt status unit. A behavioural model is advanced on
// every rising edge, and the outputs are compared every cycle.
module sim_spi_irq_status;
    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] rx_level = '0, tx_level = '0;
    logic          rx_frame_done = 1'b0, rx_pop = 1'b0, bit_tick = 1'b0;
    logic [1:0]    clr_w1c = '0, reg_sel = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    // Model state
    logic [3:0] m_mask = '0;
    bit         m_ovr = 0, m_tmo = 0;
    int         m_cnt = 0;

    always #2 clk = ~clk;

    spi_irq_status #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
        .rx_frame_done(rx_frame_done), .rx_pop(rx_pop), .bit_tick(bit_tick),
        .clr_w1c(clr_w1c), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Reference model update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = '0; m_ovr = 0; m_tmo = 0; m_cnt = 0;
        end else begin
            bit ovr_set, tmo_set;
            ovr_set = rx_frame_done && !rx_pop && (int'(rx_level) == DEPTH);
            tmo_set = 0;
            if (rx_pop || rx_frame_done || rx_level == 0) m_cnt = 0;
            else if (bit_tick && m_cnt < 32) begin
                m_cnt++;
                if (m_cnt == 32) tmo_set = 1;
            end
            if (ovr_set) m_ovr = 1; else if (clr_w1c[0]) m_ovr = 0;
            if (tmo_set) m_tmo = 1; else if (clr_w1c[1]) m_tmo = 0;
            if (reg_we && reg_sel == 2'd0) m_mask = reg_wdata[3:0];
        end
    end

    function automatic logic [3:0] exp_raw();
        return {int'(tx_level) <= DEPTH / 2, int'(rx_level) >= DEPTH / 2, m_tmo, m_ovr};
    endfunction

    task automatic compare(input string tag);
        logic [31:0] e_rd;
        logic        e_irq;
        e_rd = '0;
        case (reg_sel)
            2'd0: e_rd[3:0] = m_mask;
            2'd1: e_rd[3:0] = exp_raw();
            2'd2: e_rd[3:0] = exp_raw() & m_mask;
            default: e_rd = '0;
        endcase
        e_irq = |(exp_raw() & m_mask);
        vectors++;
        if (reg_rdata !== e_rd || irq !== e_irq) begin
            errors++;
            $display("FIFO-status FAIL %s sel=%0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                     tag, reg_sel, reg_rdata, irq, e_rd, e_irq);
        end
    endtask

    task automatic drive(input int rl, input int tl, input bit fd, input bit pp,
                         input bit bt, input int sel, input bit we,
                         input logic [31:0] wd, input int cl, input string tag);
        @(negedge clk);
        rx_level = LW'(rl); tx_level = LW'(tl); rx_frame_done = fd; rx_pop = pp;
        bit_tick = bt; reg_sel = 2'(sel); reg_we = we; reg_wdata = wd;
        clr_w1c = 2'(cl);
        #1 compare(tag);
    endtask

    // Read all three registers with no events active.
    task automatic read_all(input int rl, input int tl, input string tag);
        for (int s = 0; s < 4; s++) drive(rl, tl, 0, 0, 0, s, 0, '0, 0, tag);
    endtask

    initial begin
        // R2: reset state
        repeat (2) drive(0, 0, 0, 0, 0, 1, 0, '0, 0, "R2");
        rst_n = 1'b1;
        read_all(0, 0, "R2");
        // R11, R1: reserved mask bits ignored; write via another select ignored
        drive(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFF5, 0, "R11");
        read_all(0, 0, "R11");
        drive(0, 0, 0, 0, 0, 1, 1, 32'h0000_000A, 0, "R11");
        read_all(0, 0, "R1");
        drive(0, 0, 0, 0, 0, 0, 1, 32'h0000_000F, 0, "R4");
        // R9, R10, R3, R5: threshold sweep with mask on and off
        for (int m = 0; m < 2; m++) begin
            drive(0, 0, 0, 0, 0, 0, 1, m ? 32'h4 : 32'h0, 0, "R3");
            for (int l = 0; l <= DEPTH; l++) begin
                read_all(l, DEPTH - l, "R9");
                read_all(0, l, "R10");
            end
        end
        drive(0, 0, 0, 0, 0, 0, 1, 32'hF, 0, "R5");
        // R6: overrun only when full and not popped
        drive(7, 0, 1, 0, 0, 1, 0, '0, 0, "R6");
        drive(8, 0, 1, 1, 0, 1, 0, '0, 0, "R6");
        drive(8, 0, 0, 0, 0, 1, 0, '0, 0, "R6");
        drive(8, 0, 1, 0, 0, 1, 0, '0, 0, "R6");
        read_all(8, 0, "R6");
        // R8: clear, then coincident set and clear
        drive(8, 0, 0, 0, 0, 1, 0, '0, 1, "R8");
        drive(8, 0, 1, 0, 0, 1, 0, '0, 1, "R8");
        read_all(8, 0, "R8");
        drive(0, 0, 0, 0, 0, 1, 0, '0, 1, "R8");
        read_all(0, 0, "R8");
        // R7: 31 ticks then a pop restart, then a full 32
        for (int i = 0; i < 31; i++) drive(3, 0, 0, 0, 1, 1, 0, '0, 0, "R7");
        drive(3, 0, 0, 1, 1, 1, 0, '0, 0, "R7");
        for (int i = 0; i < 31; i++) drive(3, 0, 0, 0, i % 2 == 0, 2, 0, '0, 0, "R7");
        for (int i = 0; i < 40; i++) drive(3, 0, 0, 0, 1, 1, 0, '0, 0, "R7");
        // R8: clear while saturated, then 32nd tick coinciding with clear
        drive(3, 0, 0, 0, 1, 1, 0, '0, 2, "R8");
        drive(0, 0, 0, 0, 1, 1, 0, '0, 0, "R7");
        for (int i = 0; i < 31; i++) drive(2, 0, 0, 0, 1, 1, 0, '0, 0, "R7");
        drive(2, 0, 0, 0, 1, 1, 0, '0, 2, "R8");
        read_all(2, 0, "R8");
        // Random mix covering all functions
        for (int i = 0; i < 3000; i++) begin
            int rl;
            rl = ($urandom_range(0, 3) == 0) ? DEPTH : $urandom_range(0, DEPTH);
            drive(rl, $urandom_range(0, DEPTH), $urandom_range(0, 15) == 0,
                  $urandom_range(0, 63) == 0, $urandom_range(0, 1),
                  $urandom_range(0, 3), $urandom_range(0, 31) == 0,
                  $urandom(), ($urandom_range(0, 15) == 0) ? $urandom_range(1, 3) : 0,
                  "R4");
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 50000);
        if (!finished) begin
            errors++;
            $display("FIFO-status FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule